// File: doc/BRIEF.md
# Link Request Header Framer

This block turns one link-channel request into the ordered byte sequence that a transmit buffer expects. It writes the byte sequence and then starts the transfer. A request carries a type flag (native or I2C-tunnelled), a 4-bit command code, a 20-bit target address, a payload length and a defer delay. One request is accepted in a single cycle through a valid/ready pair. The block then runs a fixed sequence without further help. First it programs the total byte count and the scaled start delay. Then it writes the three address/command bytes, the optional length byte and any outgoing payload into the buffer. Last, it clears a pending completion flag, waits for the completion status to drop and fires a one-cycle go strobe.

Payload bytes enter through a streaming port with its own valid/ready handshake, and the source may pause between bytes. Only write commands pull payload. A read or an address-only request never raises the payload ready signal. Line coding, sync patterns and the electrical layer sit outside this block.

Top module: `aux_req_framer`

## Requirements
- R1: The first buffer byte has the 4-bit command code in bits 7:4 and address bits 19:16 in bits 3:0. `buf_idx_clr` is high in the same cycle as that write and in no other.
- R2: The second buffer byte is address bits 15:8 and the third is address bits 7:0.
- R3: When the request length is nonzero, a fourth byte equal to length minus one follows the address. A zero-length request writes only three bytes.
- R4: `cfg_bytes` equals 3 for a zero length and 4 otherwise, plus the length when the request is a write. It also equals the number of buffer writes before `go`.
- R5: A request is a write when `req_i2c`=0 with code 4'h8, or `req_i2c`=1 with code 4'h0 or 4'h4. Every other combination is a read. Only writes raise `pay_ready` and load payload bytes into the buffer after the header, in arrival order.
- R6: `cfg_delay` equals ten times the captured `req_delay`. It is valid in the cycle `cfg_wr` is high, which comes before the first buffer write.
- R7: The strobes come one per cycle in this order: `cfg_wr`, the buffer writes, one `done_ack` pulse, then one `go` pulse.
- R8: After `done_ack`, `go` is withheld while `done_sts` is high. `go` is issued in the cycle after `done_sts` is first sampled low.
- R9: `req_ready` is high only when idle. `busy` is high from the cycle after acceptance through the `go` cycle. Request inputs seen while busy have no effect on the output sequence.
- R10: After reset, `busy`, `cfg_wr`, `buf_wr`, `done_ack` and `go` are low and `req_ready` is high.
- R11: While `pay_valid` is low during the payload phase, no buffer write happens and the sequence holds its place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to accept |
| req_i2c | input | 1 | 1 = I2C-tunnelled, 0 = native |
| req_action | input | 4 | Command code |
| req_addr | input | 20 | Target address |
| req_len | input | LEN_W | Payload length in bytes (0..MAX_LEN) |
| req_delay | input | DLY_W | Defer delay, in units of 10 start-delay ticks |
| pay_valid | input | 1 | Payload byte present |
| pay_ready | output | 1 | Payload byte taken this cycle when valid |
| pay_data | input | 8 | Payload byte |
| buf_wr | output | 1 | Buffer write strobe |
| buf_idx_clr | output | 1 | Reset buffer index to 0 for this write |
| buf_data | output | 8 | Buffer write data |
| cfg_wr | output | 1 | Byte count and start delay strobe |
| cfg_bytes | output | CNT_W | Total bytes to transmit |
| cfg_delay | output | DLY_W+4 | Start delay |
| done_ack | output | 1 | Acknowledge pending completion |
| done_sts | input | 1 | Completion status from the channel |
| go | output | 1 | Start transfer pulse |
| busy | output | 1 | Request in progress |

## Verification
The bench uses the default build: MAX_LEN of 16, which gives 5-bit lengths and counts, and an 8-bit delay that scales to a 12-bit start delay. With these values the longest write reaches 20 buffer bytes. The largest delay, 255, maps to 2550 and so exercises the top bits of the scaler. A 16-byte read takes the length byte to 8'h0F. Zero-length native and tunnelled writes exercise the 3-byte frame. Tunnelled codes are mixed with native ones, and payload streams are fed both with and without stalls.

// File: rtl/aux_frm_pkg.sv
package aux_frm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CFG,
        ST_HDR,
        ST_LEN,
        ST_PAY,
        ST_ACK,
        ST_WAIT,
        ST_GO
    } frm_state_e;

    localparam logic [3:0] CMD_NATIVE_WR   = 4'h8;
    localparam logic [3:0] CMD_TUNNEL_WR   = 4'h0;
    localparam logic [3:0] CMD_TUNNEL_WR_M = 4'h4;

    localparam logic [1:0] SLOT_CMD_HI  = 2'd0;
    localparam logic [1:0] SLOT_ADDR_MI = 2'd1;
    localparam logic [1:0] SLOT_ADDR_LO = 2'd2;
    localparam logic [1:0] SLOT_LENGTH  = 2'd3;

endpackage

// File: rtl/aux_frm_classify.sv
module aux_frm_classify #(
    parameter int LEN_W = 5,
    parameter int CNT_W = 5
) (
    input  logic             is_i2c,
    input  logic [3:0]       action,
    input  logic [LEN_W-1:0] len,
    output logic             is_write,
    output logic [CNT_W-1:0] wr_bytes
);
    import aux_frm_pkg::*;

    always_comb begin
        if (is_i2c) begin
            is_write = (action == CMD_TUNNEL_WR) || (action == CMD_TUNNEL_WR_M);
        end else begin
            is_write = (action == CMD_NATIVE_WR);
        end
        wr_bytes = (len == '0) ? CNT_W'(3) : CNT_W'(4);
        if (is_write) begin
            wr_bytes = wr_bytes + CNT_W'(len);
        end
    end

endmodule

// File: rtl/aux_frm_scale10.sv
module aux_frm_scale10 #(
    parameter int DLY_W = 8
) (
    input  logic [DLY_W-1:0] dly_in,
    output logic [DLY_W+3:0] dly_out
);
    localparam int OUT_W = DLY_W + 4;

    always_comb begin
        dly_out = (OUT_W'(dly_in) << 3) + (OUT_W'(dly_in) << 1);
    end

endmodule

// File: rtl/aux_frm_bytesel.sv
module aux_frm_bytesel #(
    parameter int LEN_W = 5
) (
    input  logic [1:0]       slot,
    input  logic [3:0]       action,
    input  logic [19:0]      addr,
    input  logic [LEN_W-1:0] len,
    output logic [7:0]       byte_out
);
    import aux_frm_pkg::*;

    always_comb begin
        unique case (slot)
            SLOT_CMD_HI:  byte_out = {action, addr[19:16]};
            SLOT_ADDR_MI: byte_out = addr[15:8];
            SLOT_ADDR_LO: byte_out = addr[7:0];
            default:      byte_out = 8'(len) - 8'd1;
        endcase
    end

endmodule

// File: rtl/aux_req_framer.sv
module aux_req_framer #(
    parameter int MAX_LEN = 16,
    parameter int DLY_W   = 8,
    parameter int LEN_W   = $clog2(MAX_LEN + 1),
    parameter int CNT_W   = $clog2(MAX_LEN + 5)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic             req_i2c,
    input  logic [3:0]       req_action,
    input  logic [19:0]      req_addr,
    input  logic [LEN_W-1:0] req_len,
    input  logic [DLY_W-1:0] req_delay,
    input  logic             pay_valid,
    output logic             pay_ready,
    input  logic [7:0]       pay_data,
    output logic             buf_wr,
    output logic             buf_idx_clr,
    output logic [7:0]       buf_data,
    output logic             cfg_wr,
    output logic [CNT_W-1:0] cfg_bytes,
    output logic [DLY_W+3:0] cfg_delay,
    output logic             done_ack,
    input  logic             done_sts,
    output logic             go,
    output logic             busy
);
    import aux_frm_pkg::*;

    typedef struct packed {
        frm_state_e       st;
        logic [1:0]       idx;
        logic [LEN_W-1:0] rem;
        logic             i2c;
        logic [3:0]       act;
        logic [19:0]      addr;
        logic [LEN_W-1:0] len;
        logic [DLY_W-1:0] dly;
    } frm_regs_t;

    frm_regs_t  r_d, r_q;
    logic       is_wr;
    logic [1:0] slot;
    logic [7:0] hdr_byte;

    aux_frm_classify #(.LEN_W(LEN_W), .CNT_W(CNT_W)) classify_i (
        .is_i2c   (r_q.i2c),
        .action   (r_q.act),
        .len      (r_q.len),
        .is_write (is_wr),
        .wr_bytes (cfg_bytes)
    );

    aux_frm_scale10 #(.DLY_W(DLY_W)) scale_i (
        .dly_in  (r_q.dly),
        .dly_out (cfg_delay)
    );

    assign slot = (r_q.st == ST_LEN) ? SLOT_LENGTH : r_q.idx;

    aux_frm_bytesel #(.LEN_W(LEN_W)) bytesel_i (
        .slot     (slot),
        .action   (r_q.act),
        .addr     (r_q.addr),
        .len      (r_q.len),
        .byte_out (hdr_byte)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st   = ST_CFG;
                    r_d.i2c  = req_i2c;
                    r_d.act  = req_action;
                    r_d.addr = req_addr;
                    r_d.len  = req_len;
                    r_d.dly  = req_delay;
                end
            end
            ST_CFG: begin
                r_d.st  = ST_HDR;
                r_d.idx = 2'd0;
            end
            ST_HDR: begin
                if (r_q.idx == SLOT_ADDR_LO) begin
                    r_d.st = (r_q.len != '0) ? ST_LEN : ST_ACK;
                end else begin
                    r_d.idx = r_q.idx + 2'd1;
                end
            end
            ST_LEN: begin
                r_d.rem = r_q.len;
                r_d.st  = is_wr ? ST_PAY : ST_ACK;
            end
            ST_PAY: begin
                if (pay_valid) begin
                    r_d.rem = r_q.rem - LEN_W'(1);
                    if (r_q.rem == LEN_W'(1)) begin
                        r_d.st = ST_ACK;
                    end
                end
            end
            ST_ACK:  r_d.st = ST_WAIT;
            ST_WAIT: begin
                if (!done_sts) begin
                    r_d.st = ST_GO;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        req_ready   = (r_q.st == ST_IDLE);
        busy        = (r_q.st != ST_IDLE);
        cfg_wr      = (r_q.st == ST_CFG);
        pay_ready   = (r_q.st == ST_PAY);
        done_ack    = (r_q.st == ST_ACK);
        go          = (r_q.st == ST_GO);
        buf_idx_clr = (r_q.st == ST_HDR) && (r_q.idx == SLOT_CMD_HI);
        buf_wr      = (r_q.st == ST_HDR) || (r_q.st == ST_LEN) ||
                      ((r_q.st == ST_PAY) && pay_valid);
        if (!buf_wr) begin
            buf_data = 8'h00;
        end else if (r_q.st == ST_PAY) begin
            buf_data = pay_data;
        end else begin
            buf_data = hdr_byte;
        end
    end

endmodule

// File: rtl/aux_req_framer_chk.sv
module aux_req_framer_chk #(
    parameter int CNT_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             pay_ready,
    input logic             buf_wr,
    input logic             buf_idx_clr,
    input logic             cfg_wr,
    input logic [CNT_W-1:0] cfg_bytes,
    input logic             done_ack,
    input logic             done_sts,
    input logic             go,
    input logic             busy
);
    logic [CNT_W-1:0] seen_q;
    logic [CNT_W-1:0] want_q;
    logic             acked_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q  <= '0;
            want_q  <= '0;
            acked_q <= 1'b0;
        end else begin
            if (cfg_wr) begin
                seen_q <= '0;
                want_q <= cfg_bytes;
            end else if (buf_wr) begin
                seen_q <= seen_q + CNT_W'(1);
            end
            if (done_ack) begin
                acked_q <= 1'b1;
            end else if (go) begin
                acked_q <= 1'b0;
            end
        end
    end

    a_r1_clr_with_write: assert property (@(posedge clk) disable iff (!rst_n)
        buf_idx_clr |-> buf_wr);

    a_r4_count_matches_writes: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (seen_q == want_q));

    a_r5_pay_only_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pay_ready |-> busy);

    a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_wr, buf_wr, done_ack, go}));

    a_r7_ack_before_go: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> acked_q);

    a_r8_go_after_low: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> !$past(done_sts));

    a_r9_accept_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

    a_r9_go_ends_busy: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !busy);

    a_r9_no_ready_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !req_ready);

endmodule

bind aux_req_framer aux_req_framer_chk #(.CNT_W(CNT_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .pay_ready   (pay_ready),
    .buf_wr      (buf_wr),
    .buf_idx_clr (buf_idx_clr),
    .cfg_wr      (cfg_wr),
    .cfg_bytes   (cfg_bytes),
    .done_ack    (done_ack),
    .done_sts    (done_sts),
    .go          (go),
    .busy        (busy)
);

// File: tb/aux_req_framer_tb_top.sv
module aux_req_framer_tb_top;
    localparam int MAX_LEN = 16;
    localparam int DLY_W   = 8;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam int CNT_W   = $clog2(MAX_LEN + 5);

    localparam int K_CFG  = 0;
    localparam int K_BYTE = 1;
    localparam int K_ACK  = 2;
    localparam int K_GO   = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_i2c = 1'b0;
    logic [3:0]       req_action = '0;
    logic [19:0]      req_addr = '0;
    logic [LEN_W-1:0] req_len = '0;
    logic [DLY_W-1:0] req_delay = '0;
    logic             pay_valid = 1'b0;
    logic             pay_ready;
    logic [7:0]       pay_data = '0;
    logic             buf_wr;
    logic             buf_idx_clr;
    logic [7:0]       buf_data;
    logic             cfg_wr;
    logic [CNT_W-1:0] cfg_bytes;
    logic [DLY_W+3:0] cfg_delay;
    logic             done_ack;
    logic             done_sts = 1'b0;
    logic             go;
    logic             busy;

    int    checks = 0;
    int    fails = 0;
    int    exp_kind[$];
    int    exp_val[$];
    string exp_tag[$];
    int    pay_q[$];

    bit    cur_wr = 1'b0;
    bit    stall_mode = 1'b0;
    bit    sts_init = 1'b0;
    bit    sts_load = 1'b0;
    int    hold_ld = 0;
    int    hs_cnt = 0;
    int    ack_cnt = 0;
    bit    prev_done = 1'b0;

    always #4 clk = ~clk;

    aux_req_framer #(.MAX_LEN(MAX_LEN), .DLY_W(DLY_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_i2c(req_i2c),
        .req_action(req_action), .req_addr(req_addr), .req_len(req_len),
        .req_delay(req_delay),
        .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
        .buf_wr(buf_wr), .buf_idx_clr(buf_idx_clr), .buf_data(buf_data),
        .cfg_wr(cfg_wr), .cfg_bytes(cfg_bytes), .cfg_delay(cfg_delay),
        .done_ack(done_ack), .done_sts(done_sts), .go(go), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic observe(input int kind, input int val);
        int ek;
        int ev;
        string et;
        if (exp_kind.size() == 0) begin
            check(1'b0, "R7 unexpected strobe", kind, -1);
        end else begin
            ek = exp_kind.pop_front();
            ev = exp_val.pop_front();
            et = exp_tag.pop_front();
            check(ek == kind, {et, " kind"}, kind, ek);
            check(ev == val, et, val, ev);
        end
    endtask

    task automatic push(input int kind, input int val, input string tag);
        exp_kind.push_back(kind);
        exp_val.push_back(val);
        exp_tag.push_back(tag);
    endtask

    // monitor: samples away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (cfg_wr)   observe(K_CFG, int'(cfg_bytes) * 4096 + int'(cfg_delay));
            if (buf_wr)   observe(K_BYTE, int'(buf_idx_clr) * 256 + int'(buf_data));
            if (done_ack) observe(K_ACK, 0);
            if (go) begin
                observe(K_GO, 0);
                check(prev_done == 1'b0, "R8 go while status high", int'(prev_done), 0);
            end
            if (busy && req_ready) check(1'b0, "R9 ready while busy", 1, 0);
            if (pay_ready && !cur_wr) check(1'b0, "R5 payload pulled on read", 1, 0);
            if (pay_valid && pay_ready) hs_cnt++;
            if (done_ack) ack_cnt++;
            prev_done = done_sts;
        end
    end

    // payload source and completion status model
    initial begin
        int  pops = 0;
        int  acks_used = 0;
        int  hold_left = 0;
        bit  phase = 1'b0;
        forever begin
            @(posedge clk);
            #2;
            while (pops < hs_cnt) begin
                if (pay_q.size() > 0) void'(pay_q.pop_front());
                pops++;
            end
            if (sts_load) begin
                done_sts  = sts_init;
                hold_left = hold_ld;
                sts_load  = 1'b0;
            end else if (acks_used < ack_cnt) begin
                if (hold_left > 0) begin
                    hold_left--;
                end else begin
                    done_sts = 1'b0;
                    acks_used++;
                end
            end
            phase     = ~phase;
            pay_valid = (pay_q.size() > 0) && (!stall_mode || phase);
            pay_data  = (pay_q.size() > 0) ? 8'(pay_q[0]) : 8'h00;
        end
    end

    task automatic send(input bit i2c, input logic [3:0] act, input logic [19:0] addr,
                        input int len, input int dly, input bit stall,
                        input bit pend, input int hold);
        bit wr;
        int nb;
        wr = i2c ? (act == 4'h0 || act == 4'h4) : (act == 4'h8);
        nb = ((len == 0) ? 3 : 4) + (wr ? len : 0);
        @(posedge clk);
        #1;
        cur_wr     = wr;
        stall_mode = stall;
        sts_init   = pend;
        hold_ld    = hold;
        sts_load   = 1'b1;
        push(K_CFG, nb * 4096 + dly * 10, "R4/R6 count and delay");
        push(K_BYTE, 256 + {act, addr[19:16]}, "R1 first byte");
        push(K_BYTE, int'(addr[15:8]), "R2 middle address byte");
        push(K_BYTE, int'(addr[7:0]), "R2 low address byte");
        if (len != 0) push(K_BYTE, (len - 1) & 8'hFF, "R3 length byte");
        if (wr) begin
            for (int i = 0; i < len; i++) begin
                pay_q.push_back((addr[7:0] + i * 37 + 5) & 8'hFF);
                push(K_BYTE, (addr[7:0] + i * 37 + 5) & 8'hFF,
                     stall ? "R11 stalled payload" : "R5 payload byte");
            end
        end
        push(K_ACK, 0, "R7 ack");
        push(K_GO, 0, "R8 go");
        req_valid  = 1'b1;
        req_i2c    = i2c;
        req_action = act;
        req_addr   = addr;
        req_len    = LEN_W'(len);
        req_delay  = DLY_W'(dly);
        do @(negedge clk); while (!req_ready);
        @(posedge clk);
        #1;
        // R9: garbage while busy must not alter the sequence
        req_i2c    = ~i2c;
        req_action = ~act;
        req_addr   = ~addr;
        req_len    = LEN_W'(3);
        req_delay  = 8'hAA;
        repeat (3) @(posedge clk);
        #1;
        req_valid = 1'b0;
        while (exp_kind.size() != 0 || busy) @(negedge clk);
        check(pay_q.size() == 0, "R5 payload fully consumed", pay_q.size(), 0);
        @(negedge clk);
        check(req_ready == 1'b1, "R9 ready after go", int'(req_ready), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0, "R10 busy after reset", int'(busy), 0);
        check(req_ready == 1'b1, "R10 ready after reset", int'(req_ready), 1);
        check({cfg_wr, buf_wr, done_ack, go} == 4'b0, "R10 strobes after reset",
              int'({cfg_wr, buf_wr, done_ack, go}), 0);
        send(1'b0, 4'h8, 20'hA5C3E, 4,  5,   1'b0, 1'b1, 3);
        send(1'b0, 4'h9, 20'h01234, 16, 0,   1'b0, 1'b0, 0);
        send(1'b0, 4'h8, 20'hF0F0F, 0,  1,   1'b0, 1'b1, 0);
        send(1'b1, 4'h4, 20'h00050, 2,  17,  1'b1, 1'b0, 0);
        send(1'b1, 4'h5, 20'h00050, 1,  3,   1'b0, 1'b1, 5);
        send(1'b1, 4'h0, 20'h7FFFF, 16, 255, 1'b1, 1'b1, 2);
        send(1'b1, 4'h0, 20'h00037, 0,  2,   1'b0, 1'b0, 0);
        send(1'b0, 4'h0, 20'h8ABCD, 3,  4,   1'b0, 1'b1, 1);
        send(1'b1, 4'h8, 20'h12345, 2,  9,   1'b0, 1'b0, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule